// File: doc/BRIEF.md
# Addressed Queue-Status Word Bus

This block puts the almost-full status of a chosen group of eight queues onto an 8-bit status bus. Each queue has one active-low status bit (0 = almost full, 1 = not almost full). The queues are grouped into words of eight. Word `w` covers queues `8w` to `8w+7`. The host picks a word by placing its index on the low four bits of the write address bus and raising the flag strobe for one clock edge.

The bus is a register. It shows the chosen word one cycle after the selection edge. After that it keeps tracking the live status of that same word every cycle, until another word is chosen. A mode pin is sampled while reset is held. The addressed behaviour is active only when that pin was low. In the other case the bus stays idle-high and strobes do nothing.

A configured-queue count limits which words may be chosen. Bus bits that belong to queues beyond the count are forced high.

Top module: `qstat_word_bus`

## Requirements
- R1: The mode pin `mode_sel` is captured on every clock edge while `rst_n` is low. Low selects addressed mode. Changes on the pin after reset is released have no effect.
- R2: When the captured mode is not addressed mode, `status_bus` is 8'hFF and strobes are ignored.
- R3: On a rising edge where `flag_strobe` is high, the word index is taken from `wr_addr[3:0]`. The upper address bits do not matter. Address changes without the strobe have no effect.
- R4: The edge after the selection edge loads the newly selected word onto `status_bus`. Between the two edges the bus still shows the previous word.
- R5: Bit `i` of `status_bus` equals `q_afull_n[8w+i]`, where `w` is the selected word.
- R6: A bus bit whose queue number is at or above the configured count (`queue_count`, with values above 128 treated as 128) is driven 1.
- R7: A strobe whose index is above the last configured word, `ceil(count/8)-1`, is ignored and the previous selection is kept. With a count of 0, every strobe is ignored.
- R8: While the selection is unchanged, `status_bus` follows changes on `q_afull_n` with a lag of one cycle.
- R9: During reset `status_bus` is 8'hFF. Word 0 is the selection after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous master reset, active low |
| mode_sel | input | 1 | Mode pin, sampled during reset; low = addressed mode |
| q_afull_n | input | 128 | Per-queue almost-full status, active low |
| wr_addr | input | 8 | Write address bus; bits 3:0 hold the word index |
| flag_strobe | input | 1 | Status-word select strobe |
| queue_count | input | 8 | Number of configured queues |
| status_bus | output | 8 | Selected status word |

## Verification
A word switch and a live status change can land in the same cycle. The bench provokes this by presenting a strobe on the same cycle that it flips status bits in both the old word and the new word.

After the first edge the bus must show the old word with its updated bits. After the second edge it must show the new word with its updated bits. This proves that the refresh path and the selection register do not mask each other.

// File: rtl/qsw_pkg.sv
package qsw_pkg;

  // Clamp a configured-queue count to the number of physical queues.
  function automatic int clamp_count(int count, int max_q);
    return (count > max_q) ? max_q : count;
  endfunction

  // Number of words holding at least one configured queue.
  function automatic int words_in_use(int count, int max_q, int wbits);
    int c;
    c = clamp_count(count, max_q);
    return (c + wbits - 1) / wbits;
  endfunction

  // True when queue number q lies inside the configured range.
  function automatic logic queue_live(int q, int count, int max_q);
    return q < clamp_count(count, max_q);
  endfunction

endpackage

// File: rtl/qsw_mode_latch.sv
module qsw_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_pin,
  output logic direct_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) direct_o <= !mode_pin;
  end
endmodule

// File: rtl/qsw_word_select.sv
module qsw_word_select #(
  parameter int MAX_Q = 128,
  parameter int WBITS = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             strobe,
  input  logic [IDX_W-1:0] idx,
  input  logic [CNT_W-1:0] count,
  output logic [IDX_W-1:0] word_sel_o,
  output logic             accept_o
);
  import qsw_pkg::*;

  logic in_range;

  always_comb begin
    in_range = int'(idx) < words_in_use(int'(count), MAX_Q, WBITS);
    accept_o = enable && strobe && in_range;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        word_sel_o <= '0;
    else if (accept_o) word_sel_o <= idx;
  end
endmodule

// File: rtl/qsw_word_mux.sv
module qsw_word_mux #(
  parameter int MAX_Q = 128,
  parameter int WBITS = 8,
  parameter int IDX_W = 4,
  parameter int CNT_W = 8
) (
  input  logic [IDX_W-1:0] word_sel,
  input  logic [MAX_Q-1:0] status,
  input  logic [CNT_W-1:0] count,
  output logic [WBITS-1:0] word_o
);
  import qsw_pkg::*;

  logic [WBITS-1:0] slice;

  assign slice = status[int'(word_sel)*WBITS +: WBITS];

  for (genvar i = 0; i < WBITS; i++) begin : g_bit
    logic live;
    assign live      = queue_live(int'(word_sel)*WBITS + i, int'(count), MAX_Q);
    assign word_o[i] = live ? slice[i] : 1'b1;
  end
endmodule

// File: rtl/qstat_word_bus.sv
module qstat_word_bus #(
  parameter int MAX_QUEUES = 128,
  parameter int WORD_BITS  = 8,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = $clog2(MAX_QUEUES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_sel,
  input  logic [MAX_QUEUES-1:0] q_afull_n,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic                  flag_strobe,
  input  logic [CNT_W-1:0]      queue_count,
  output logic [WORD_BITS-1:0]  status_bus
);
  localparam int NUM_WORDS = MAX_QUEUES / WORD_BITS;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  // Internal events brought out by name for the checker
  logic                 direct_q;
  logic                 sel_accept;
  logic [IDX_W-1:0]     word_sel;
  logic [WORD_BITS-1:0] word_live;
  logic                 unused_addr_hi;

  assign unused_addr_hi = ^wr_addr[ADDR_W-1:IDX_W];

  qsw_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_pin (mode_sel),
    .direct_o (direct_q)
  );

  qsw_word_select #(
    .MAX_Q (MAX_QUEUES), .WBITS (WORD_BITS), .IDX_W (IDX_W), .CNT_W (CNT_W)
  ) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (direct_q),
    .strobe     (flag_strobe),
    .idx        (wr_addr[IDX_W-1:0]),
    .count      (queue_count),
    .word_sel_o (word_sel),
    .accept_o   (sel_accept)
  );

  qsw_word_mux #(
    .MAX_Q (MAX_QUEUES), .WBITS (WORD_BITS), .IDX_W (IDX_W), .CNT_W (CNT_W)
  ) u_mux (
    .word_sel (word_sel),
    .status   (q_afull_n),
    .count    (queue_count),
    .word_o   (word_live)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         status_bus <= '1;
    else if (!direct_q) status_bus <= '1;
    else                status_bus <= word_live;
  end
endmodule

// File: rtl/qsw_chk.sv
module qsw_chk #(
  parameter int MAX_QUEUES = 128,
  parameter int WORD_BITS  = 8,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 8,
  parameter int IDX_W      = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [MAX_QUEUES-1:0] q_afull_n,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [CNT_W-1:0]      queue_count,
  input logic [WORD_BITS-1:0]  status_bus,
  input logic                  direct_q,
  input logic                  sel_accept,
  input logic [IDX_W-1:0]      word_sel
);
  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(direct_q));

  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !direct_q |=> status_bus == '1);

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_accept |=> word_sel == $past(wr_addr[IDX_W-1:0]));

  // R7
  keep_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_accept |=> $stable(word_sel));

  // R5
  map_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_q && word_sel == '0 && queue_count != '0)
      |=> status_bus[0] == $past(q_afull_n[0]));

  // R6
  empty_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (direct_q && queue_count == '0) |=> status_bus == '1);

  // R9
  reset_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (status_bus == '1 && word_sel == '0));
endmodule

bind qstat_word_bus qsw_chk #(
  .MAX_QUEUES (MAX_QUEUES), .WORD_BITS (WORD_BITS), .ADDR_W (ADDR_W),
  .CNT_W (CNT_W), .IDX_W (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .q_afull_n   (q_afull_n),
  .wr_addr     (wr_addr),
  .queue_count (queue_count),
  .status_bus  (status_bus),
  .direct_q    (direct_q),
  .sel_accept  (sel_accept),
  .word_sel    (word_sel)
);

// File: tb/qstat_word_bus_test.sv
`timescale 1ns/1ps
module qstat_word_bus_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_sel = 1'b0;
  logic [127:0] stat;
  logic [7:0]   wr_addr = '0;
  logic         flag_strobe = 1'b0;
  logic [7:0]   queue_count = 8'd128;
  logic [7:0]   status_bus;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qstat_word_bus uut (
    .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel), .q_afull_n (stat),
    .wr_addr (wr_addr), .flag_strobe (flag_strobe),
    .queue_count (queue_count), .status_bus (status_bus)
  );

  // {tag, addr_hi, idx, count, expected word}
  localparam logic [23:0] VEC [11] = '{
    24'h322802, 24'h32F80F, 24'h3F5805, 24'h6231A3, 24'h7241A3,
    24'h5201A0, 24'h521101, 24'h722101, 24'h727C87, 24'h72FC8F,
    24'h72000F };

  function automatic logic [7:0] model(int w, int cnt, logic [127:0] s);
    logic [7:0] r;
    int c = (cnt > 128) ? 128 : cnt;
    for (int i = 0; i < 8; i++) r[i] = (w*8 + i < c) ? s[w*8 + i] : 1'b1;
    return r;
  endfunction

  function automatic string tag_name(logic [3:0] t);
    case (t)
      4'd3: return "R3";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: status_bus=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pick(logic [7:0] addr, logic [7:0] cnt);
    @(negedge clk);
    wr_addr = addr; queue_count = cnt; flag_strobe = 1'b1;
    @(negedge clk);
    flag_strobe = 1'b0;
  endtask

  initial begin
    for (int q = 0; q < 128; q++) stat[q] = ((q*5 + 1) % 3) != 0;
    // reset state
    repeat (3) @(negedge clk);
    chk("R9", status_bus, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", status_bus, model(0, 128, stat));
    mode_sel = 1'b1; // R1: pin change after reset has no effect

    // vector table
    for (int k = 0; k < 11; k++) begin
      pick({VEC[k][19:16], VEC[k][15:12]}, VEC[k][11:4]);
      @(negedge clk);
      chk(tag_name(VEC[k][23:20]), status_bus,
          model(int'(VEC[k][3:0]), int'(VEC[k][11:4]), stat));
    end
    chk("R1", status_bus, 8'hFF);

    // R4: one-cycle select latency, old word visible in between
    queue_count = 8'd128;
    @(negedge clk);
    wr_addr = 8'h29; flag_strobe = 1'b1;
    @(negedge clk);
    flag_strobe = 1'b0;
    chk("R4", status_bus, model(15, 128, stat));
    @(negedge clk);
    chk("R4", status_bus, model(9, 128, stat));

    // R3: address without strobe ignored
    wr_addr = 8'h24;
    repeat (2) @(negedge clk);
    chk("R3", status_bus, model(9, 128, stat));

    // R8: live refresh
    stat[72] = ~stat[72]; stat[79] = ~stat[79];
    @(negedge clk);
    chk("R8", status_bus, model(9, 128, stat));

    // Concurrent switch and status change
    wr_addr = 8'h24; flag_strobe = 1'b1;
    stat[73] = ~stat[73]; stat[33] = ~stat[33]; stat[38] = ~stat[38];
    @(negedge clk);
    flag_strobe = 1'b0;
    chk("R8", status_bus, model(9, 128, stat));
    @(negedge clk);
    chk("R4", status_bus, model(4, 128, stat));

    // R2: non-addressed mode
    rst_n = 1'b0; mode_sel = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; mode_sel = 1'b0;
    pick(8'h24, 8'd128);
    repeat (2) @(negedge clk);
    chk("R2", status_bus, 8'hFF);
    chk("R2", model(4, 128, stat) == 8'hFF ? 8'h00 : status_bus, 8'hFF);

    // back to addressed mode, word 0 after reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", status_bus, model(0, 128, stat));

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule